// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler

This block buffers dispatched instructions and sends them to execution pipelines out of program order, as soon as their operands exist. Each slot of the buffer runs its own small state machine. SLOT_FREE means the slot is empty. SLOT_WAIT means an operand is still missing. SLOT_READY means the instruction can issue. SLOT_BUSY means the instruction sits in a pipeline while its latency counts down.

A slot takes five transitions:
- *alloc-wait*: SLOT_FREE to SLOT_WAIT, when an entry is written with an operand missing.
- *alloc-ready*: SLOT_FREE to SLOT_READY, when an entry is written with both operands present.
- *wake*: SLOT_WAIT to SLOT_READY, when the result-tag bus supplies the last missing source.
- *issue*: SLOT_READY to SLOT_BUSY, when the slot wins selection and gets a unit.
- *finish*: SLOT_BUSY to SLOT_FREE, when the latency countdown expires. In that cycle the slot's destination tag is reported on the completion port of its unit, which tells the retire logic.

Instructions name one of `NGRP` resource groups, and each group has `UPG` execution units. In each group, the oldest ready instruction goes to a free unit. The unit is found by a rotating pointer, so that work spreads evenly across the units. A unit stays taken until its instruction finishes. The buffer reports how many slots are in use and the highest count seen. It raises `full` when no slot is left, and a dispatch made while `full` is high is dropped.

Top module: `sched_top`

## Requirements
- R1: After reset, all slots are free. `full` is low, `occ` and `occ_peak` are 0, and no issue or completion bit is set.
- R2: A dispatched entry whose two ready flags are set (or whose missing tags match `wk_tag` in the dispatch cycle) can issue in the cycle after dispatch at the earliest. It never issues in the dispatch cycle.
- R3: A waiting entry becomes ready only when `wk_vld` is high and `wk_tag` equals one of its missing source tags. A wakeup in cycle t allows issue in cycle t+1 at the earliest. A non-matching tag has no effect.
- R4: Among ready entries of the same group, the one dispatched earliest issues first, whatever slot it occupies.
- R5: Each group issues at most one entry per cycle. Unit k of group g is issue and completion port g*UPG+k, and its tag is bits [(g*UPG+k)*TAG_W +: TAG_W] of `iss_tag` and `done_tag`.
- R6: The unit for an issue is the first free unit at or after the group's rotating pointer, wrapping around. After an issue, the pointer moves to the unit after the one chosen. A unit stays unavailable from the cycle after its issue until its completion cycle, inclusive. If no unit is free, nothing issues.
- R7: An entry issued in cycle t with latency L (1 or more; 0 acts as 1) raises `done_vld` on its unit's port, with its destination tag, in cycle t+L. Its slot is free from cycle t+L+1.
- R8: `full` is high exactly when all DEPTH slots are in use. A dispatch while `full` is high is ignored.
- R9: `occ` gives the number of slots in use. `occ_peak` gives the largest `occ` seen since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_vld | input | 1 | Dispatch request |
| disp_src0 | input | TAG_W | First source tag |
| disp_src0_ok | input | 1 | First source already available |
| disp_src1 | input | TAG_W | Second source tag |
| disp_src1_ok | input | 1 | Second source already available |
| disp_dst | input | TAG_W | Destination tag |
| disp_grp | input | idx_w(NGRP) | Resource group |
| disp_lat | input | LAT_W | Execution latency in cycles |
| full | output | 1 | No free slot |
| wk_vld | input | 1 | Result tag broadcast valid |
| wk_tag | input | TAG_W | Broadcast result tag |
| iss_vld | output | NGRP*UPG | Issue strobe per unit |
| iss_tag | output | NGRP*UPG*TAG_W | Destination tag issued per unit |
| done_vld | output | NGRP*UPG | Completion strobe per unit |
| done_tag | output | NGRP*UPG*TAG_W | Destination tag completed per unit |
| occ | output | idx_w(DEPTH+1) | Slots in use |
| occ_peak | output | idx_w(DEPTH+1) | Highest occupancy since reset |

## Verification
The bench builds the block with DEPTH=4, two groups of two units each, 5-bit tags and 3-bit latencies. The shallow buffer means four dispatches reach the full condition, so a dropped dispatch and the drain afterwards take only a few cycles. With two units per group, the pointer's alternation can be seen directly. A three-cycle latency on one unit, while the other is also taken, produces both a cycle with no free unit and a pointer that skips a busy unit. Placing a younger entry in a lower slot than older ones shows that age, not slot position, decides selection.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2,
        SLOT_BUSY  = 2'd3
    } slot_st_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/sched_age.sv
// Age matrix: older_q[j][i] set means slot j was written before slot i.
module sched_age #(
    parameter int DEPTH = 8,
    parameter int NREQ  = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [DEPTH-1:0]                 alloc,
    input  logic [NREQ-1:0][DEPTH-1:0]       req,
    output logic [NREQ-1:0][DEPTH-1:0]       grant
);

    logic [DEPTH-1:0][DEPTH-1:0] older_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (alloc[k]) begin
                    for (int j = 0; j < DEPTH; j++) begin
                        older_q[k][j] <= 1'b0;
                        if (j != k) older_q[j][k] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        grant = '0;
        for (int r = 0; r < NREQ; r++) begin
            for (int i = 0; i < DEPTH; i++) begin
                grant[r][i] = req[r][i];
                for (int j = 0; j < DEPTH; j++) begin
                    if (j != i && req[r][j] && older_q[j][i]) grant[r][i] = 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sched_rr.sv
// Rotating unit chooser for one resource group.
module sched_rr #(
    parameter int N = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N-1:0]                      busy,
    input  logic                              adv,
    output logic                              ok,
    output logic [sched_pkg::idx_w(N)-1:0]    sel
);

    localparam int IW = sched_pkg::idx_w(N);

    logic [IW-1:0] ptr_q;

    always_comb begin
        ok  = 1'b0;
        sel = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int idx;
            idx = int'(ptr_q) + k;
            if (idx >= N) idx = idx - N;
            if (!busy[idx]) begin
                ok  = 1'b1;
                sel = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv) begin
            if (int'(sel) == N - 1) ptr_q <= '0;
            else                    ptr_q <= sel + 1'b1;
        end
    end

endmodule

// File: rtl/sched_top.sv
module sched_top #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 5,
    parameter int NGRP  = 2,
    parameter int UPG   = 2,
    parameter int LAT_W = 3
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     disp_vld,
    input  logic [TAG_W-1:0]                         disp_src0,
    input  logic                                     disp_src0_ok,
    input  logic [TAG_W-1:0]                         disp_src1,
    input  logic                                     disp_src1_ok,
    input  logic [TAG_W-1:0]                         disp_dst,
    input  logic [sched_pkg::idx_w(NGRP)-1:0]        disp_grp,
    input  logic [LAT_W-1:0]                         disp_lat,
    output logic                                     full,
    input  logic                                     wk_vld,
    input  logic [TAG_W-1:0]                         wk_tag,
    output logic [NGRP*UPG-1:0]                      iss_vld,
    output logic [NGRP*UPG*TAG_W-1:0]                iss_tag,
    output logic [NGRP*UPG-1:0]                      done_vld,
    output logic [NGRP*UPG*TAG_W-1:0]                done_tag,
    output logic [sched_pkg::idx_w(DEPTH+1)-1:0]     occ,
    output logic [sched_pkg::idx_w(DEPTH+1)-1:0]     occ_peak
);

    import sched_pkg::*;

    localparam int GRP_W  = idx_w(NGRP);
    localparam int UNIT_W = idx_w(UPG);
    localparam int CNT_W  = idx_w(DEPTH + 1);

    typedef struct packed {
        logic [TAG_W-1:0]  s0;
        logic              r0;
        logic [TAG_W-1:0]  s1;
        logic              r1;
        logic [TAG_W-1:0]  dst;
        logic [GRP_W-1:0]  grp;
        logic [LAT_W-1:0]  cnt;
        logic [UNIT_W-1:0] unit;
    } ent_t;

    slot_st_e st_q [DEPTH];
    slot_st_e st_d [DEPTH];
    ent_t     ent_q [DEPTH];
    ent_t     ent_d [DEPTH];

    logic [DEPTH-1:0]                alloc;
    logic [DEPTH-1:0]                finish;
    logic [NGRP-1:0][DEPTH-1:0]      rdy_req;
    logic [NGRP-1:0][DEPTH-1:0]      pick;
    logic [NGRP-1:0][UPG-1:0]        gbusy;
    logic [NGRP-1:0]                 unit_ok;
    logic [NGRP-1:0]                 fire;
    logic [NGRP-1:0][UNIT_W-1:0]     unit_sel;

    // Slot allocation: lowest free slot takes the dispatch.
    always_comb begin
        logic found;
        found = 1'b0;
        alloc = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && st_q[i] == SLOT_FREE) begin
                alloc[i] = disp_vld;
                found    = 1'b1;
            end
        end
        full = !found;
    end

    // Slot classification for selection, unit occupancy and completion.
    always_comb begin
        rdy_req = '0;
        gbusy   = '0;
        finish  = '0;
        occ     = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q[i] != SLOT_FREE) occ = occ + CNT_W'(1);
            for (int g = 0; g < NGRP; g++) begin
                if (st_q[i] == SLOT_READY && ent_q[i].grp == GRP_W'(g)) rdy_req[g][i] = 1'b1;
            end
            if (st_q[i] == SLOT_BUSY) begin
                gbusy[ent_q[i].grp][ent_q[i].unit] = 1'b1;
                if (ent_q[i].cnt <= LAT_W'(1)) finish[i] = 1'b1;
            end
        end
    end

    sched_age #(.DEPTH(DEPTH), .NREQ(NGRP)) u_age (
        .clk   (clk),
        .rst_n (rst_n),
        .alloc (alloc),
        .req   (rdy_req),
        .grant (pick)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        sched_rr #(.N(UPG)) u_rr (
            .clk   (clk),
            .rst_n (rst_n),
            .busy  (gbusy[g]),
            .adv   (fire[g]),
            .ok    (unit_ok[g]),
            .sel   (unit_sel[g])
        );
        assign fire[g] = (|pick[g]) && unit_ok[g];
    end

    // Output process: issue and completion ports.
    always_comb begin
        int u;
        u        = 0;
        iss_vld  = '0;
        iss_tag  = '0;
        done_vld = '0;
        done_tag = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (fire[g]) begin
                u = g * UPG + int'(unit_sel[g]);
                iss_vld[u] = 1'b1;
                for (int i = 0; i < DEPTH; i++) begin
                    if (pick[g][i]) iss_tag[u*TAG_W +: TAG_W] = ent_q[i].dst;
                end
            end
        end
        for (int i = 0; i < DEPTH; i++) begin
            if (finish[i]) begin
                u = int'(ent_q[i].grp) * UPG + int'(ent_q[i].unit);
                done_vld[u] = 1'b1;
                done_tag[u*TAG_W +: TAG_W] = ent_q[i].dst;
            end
        end
    end

    // Next-state process: one state machine per slot.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            st_d[i]  = st_q[i];
            ent_d[i] = ent_q[i];
            unique case (st_q[i])
                SLOT_FREE: begin
                    if (alloc[i]) begin
                        ent_d[i].s0   = disp_src0;
                        ent_d[i].r0   = disp_src0_ok || (wk_vld && wk_tag == disp_src0);
                        ent_d[i].s1   = disp_src1;
                        ent_d[i].r1   = disp_src1_ok || (wk_vld && wk_tag == disp_src1);
                        ent_d[i].dst  = disp_dst;
                        ent_d[i].grp  = disp_grp;
                        ent_d[i].cnt  = disp_lat;
                        ent_d[i].unit = '0;
                        st_d[i] = (ent_d[i].r0 && ent_d[i].r1) ? SLOT_READY : SLOT_WAIT;
                    end
                end
                SLOT_WAIT: begin
                    if (wk_vld && wk_tag == ent_q[i].s0) ent_d[i].r0 = 1'b1;
                    if (wk_vld && wk_tag == ent_q[i].s1) ent_d[i].r1 = 1'b1;
                    if (ent_d[i].r0 && ent_d[i].r1) st_d[i] = SLOT_READY;
                end
                SLOT_READY: begin
                    if (fire[ent_q[i].grp] && pick[ent_q[i].grp][i]) begin
                        st_d[i]       = SLOT_BUSY;
                        ent_d[i].unit = unit_sel[ent_q[i].grp];
                    end
                end
                SLOT_BUSY: begin
                    if (finish[i]) st_d[i] = SLOT_FREE;
                    else           ent_d[i].cnt = ent_q[i].cnt - 1'b1;
                end
                default: st_d[i] = SLOT_FREE;
            endcase
        end
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i]  <= SLOT_FREE;
                ent_q[i] <= '0;
            end
            occ_peak <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i]  <= st_d[i];
                ent_q[i] <= ent_d[i];
            end
            if (occ > occ_peak) occ_peak <= occ;
        end
    end

endmodule

// File: rtl/sched_chk.sv
module sched_chk #(
    parameter int DEPTH = 8,
    parameter int NGRP  = 2,
    parameter int UPG   = 2
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  full,
    input logic [NGRP*UPG-1:0]                   iss_vld,
    input logic [NGRP*UPG-1:0]                   done_vld,
    input logic [sched_pkg::idx_w(DEPTH+1)-1:0]  occ,
    input logic [sched_pkg::idx_w(DEPTH+1)-1:0]  occ_peak
);

    AST_FULL_OCC: assert property (@(posedge clk) disable iff (!rst_n) full |-> (int'(occ) == DEPTH)); // R8
    AST_NO_GROW_FULL: assert property (@(posedge clk) disable iff (!rst_n) full |=> (occ <= $past(occ))); // R8
    AST_PEAK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) occ_peak >= $past(occ_peak)); // R9
    AST_EMPTY_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) (occ == '0) |-> (iss_vld == '0)); // R2
    AST_UNIT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) (iss_vld & done_vld) == '0); // R6
    AST_DONE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (done_vld != '0) |-> (occ != '0)); // R7

    for (genvar g = 0; g < NGRP; g++) begin : g_one
        AST_GRP_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(iss_vld[g*UPG +: UPG])); // R5
    end

endmodule

bind sched_top sched_chk #(.DEPTH(DEPTH), .NGRP(NGRP), .UPG(UPG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .full     (full),
    .iss_vld  (iss_vld),
    .done_vld (done_vld),
    .occ      (occ),
    .occ_peak (occ_peak)
);

// File: tb/sim_sched_top.sv
module sim_sched_top;

    localparam int DEPTH = 4;
    localparam int TAG_W = 5;
    localparam int NGRP  = 2;
    localparam int UPG   = 2;
    localparam int LAT_W = 3;
    localparam int NU    = NGRP * UPG;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_vld, disp_src0_ok, disp_src1_ok, wk_vld;
    logic [TAG_W-1:0] disp_src0, disp_src1, disp_dst, wk_tag;
    logic [0:0] disp_grp;
    logic [LAT_W-1:0] disp_lat;
    logic full;
    logic [NU-1:0] iss_vld, done_vld;
    logic [NU*TAG_W-1:0] iss_tag, done_tag;
    logic [2:0] occ, occ_peak;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    sched_top #(.DEPTH(DEPTH), .TAG_W(TAG_W), .NGRP(NGRP), .UPG(UPG), .LAT_W(LAT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .disp_vld(disp_vld), .disp_src0(disp_src0),
        .disp_src0_ok(disp_src0_ok), .disp_src1(disp_src1), .disp_src1_ok(disp_src1_ok),
        .disp_dst(disp_dst), .disp_grp(disp_grp), .disp_lat(disp_lat), .full(full),
        .wk_vld(wk_vld), .wk_tag(wk_tag), .iss_vld(iss_vld), .iss_tag(iss_tag),
        .done_vld(done_vld), .done_tag(done_tag), .occ(occ), .occ_peak(occ_peak)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int itag(input int u);
        return int'(iss_tag[u*TAG_W +: TAG_W]);
    endfunction

    function automatic int dtag(input int u);
        return int'(done_tag[u*TAG_W +: TAG_W]);
    endfunction

    // Start a new cycle: wait for the falling edge and idle all inputs.
    task automatic nxt();
        @(negedge clk);
        disp_vld = 0; disp_src0 = 0; disp_src0_ok = 0; disp_src1 = 0; disp_src1_ok = 0;
        disp_dst = 0; disp_grp = 0; disp_lat = 0; wk_vld = 0; wk_tag = 0;
    endtask

    task automatic disp(input int s0, input bit ok0, input int dst, input int grp, input int lat);
        disp_vld = 1; disp_src0 = TAG_W'(s0); disp_src0_ok = ok0;
        disp_src1 = 5'd3; disp_src1_ok = 1; disp_dst = TAG_W'(dst);
        disp_grp = 1'(grp); disp_lat = LAT_W'(lat);
    endtask

    task automatic wake(input int t);
        wk_vld = 1; wk_tag = TAG_W'(t);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) nxt();
    endtask

    task automatic t_reset();
        nxt(); nxt(); nxt();
        rst_n = 1;
        #2;
        chk("R1 full", full, 0);
        chk("R1 occ", occ, 0);
        chk("R1 peak", occ_peak, 0);
        chk("R1 iss", iss_vld, 0);
        chk("R1 done", done_vld, 0);
    endtask

    // Ready at dispatch, latency 2, group 0, rotating pointer starts at unit 0.
    task automatic t_ready_dispatch();
        nxt(); disp(1, 1, 1, 0, 2); #2;
        chk("R2 no issue in dispatch cycle", iss_vld, 0);
        nxt(); #2;
        chk("R2 issue next cycle", iss_vld, 4'b0001);
        chk("R5 issue tag port0", itag(0), 1);
        chk("R9 occ one", occ, 1);
        nxt(); #2;
        chk("R7 no early done", done_vld, 0);
        nxt(); #2;
        chk("R7 done at t+L", done_vld, 4'b0001);
        chk("R7 done tag", dtag(0), 1);
        nxt(); #2;
        chk("R7 slot freed", occ, 0);
    endtask

    // Waiting entry, wrong tag then right tag, group 1.
    task automatic t_wakeup();
        nxt(); disp(7, 0, 2, 1, 1); #2;
        nxt(); wake(6); #2;
        chk("R3 waiting no issue", iss_vld, 0);
        chk("R9 occ", occ, 1);
        nxt(); wake(7); #2;
        chk("R3 wrong tag ignored", iss_vld, 0);
        nxt(); #2;
        chk("R3 issue after wakeup", iss_vld, 4'b0100);
        chk("R5 group1 unit0 tag", itag(2), 2);
        nxt(); #2;
        chk("R7 done lat1", done_vld, 4'b0100);
        chk("R7 done tag", dtag(2), 2);
        nxt(); #2;
        chk("R7 freed", occ, 0);
    endtask

    // Age order against slot order, unit rotation and busy-unit skip.
    task automatic t_age_rr();
        nxt(); disp(20, 0, 10, 0, 1);
        nxt(); disp(9, 0, 11, 0, 3);
        nxt(); disp(9, 0, 12, 0, 1); wake(20); #2;
        nxt(); #2;
        chk("R6 pointer at unit1", iss_vld, 4'b0010);
        chk("R3 tag10", itag(1), 10);
        nxt(); #2;
        chk("R7 done unit1", done_vld, 4'b0010);
        nxt(); disp(9, 0, 13, 0, 1);
        nxt(); wake(9); #2;
        nxt(); #2;
        chk("R4 oldest first", iss_vld, 4'b0001);
        chk("R4 oldest tag", itag(0), 11);
        nxt(); #2;
        chk("R6 rotate", iss_vld, 4'b0010);
        chk("R4 second oldest", itag(1), 12);
        nxt(); #2;
        chk("R6 no free unit", iss_vld, 0);
        chk("R7 done unit1 tag12", dtag(1), 12);
        nxt(); #2;
        chk("R6 skip busy unit", iss_vld, 4'b0010);
        chk("R4 youngest last", itag(1), 13);
        chk("R7 lat3 done", done_vld, 4'b0001);
        chk("R7 lat3 tag", dtag(0), 11);
        nxt(); #2;
        chk("R7 last done", done_vld, 4'b0010);
        idle(2); #2;
        chk("R9 drained", occ, 0);
        chk("R9 peak three", occ_peak, 3);
    endtask

    // Fill to full, dropped dispatch, drain in age order over group 1.
    task automatic t_full();
        bit bad_grp0;
        for (int k = 0; k < 4; k++) begin
            nxt(); disp(30, 0, 20 + k, 1, 1);
        end
        nxt(); #2;
        chk("R8 full", full, 1);
        chk("R8 occ four", occ, 4);
        disp(1, 1, 25, 0, 1);
        nxt(); #2;
        chk("R8 dropped dispatch no occ", occ, 4);
        chk("R8 dropped dispatch no issue", iss_vld, 0);
        chk("R9 peak four", occ_peak, 4);
        wake(30);
        nxt(); #2;
        chk("R6 grp1 ptr unit1", iss_vld, 4'b1000);
        chk("R4 drain 0", itag(3), 20);
        nxt(); #2;
        chk("R6 grp1 unit0", iss_vld, 4'b0100);
        chk("R4 drain 1", itag(2), 21);
        nxt(); #2;
        chk("R6 grp1 unit1 again", iss_vld, 4'b1000);
        chk("R4 drain 2", itag(3), 22);
        nxt(); #2;
        chk("R6 grp1 unit0 again", iss_vld, 4'b0100);
        chk("R4 drain 3", itag(2), 23);
        bad_grp0 = 0;
        for (int k = 0; k < 3; k++) begin
            nxt(); #2;
            if (iss_vld != 0) bad_grp0 = 1;
        end
        chk("R8 dropped entry never issues", bad_grp0, 0);
        chk("R8 empty after drain", occ, 0);
        chk("R8 full low", full, 0);
    endtask

    initial begin
        nxt();
        t_reset();
        t_ready_dispatch();
        idle(2);
        t_wakeup();
        idle(2);
        t_age_rr();
        idle(2);
        t_full();
        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule